// File: doc/BRIEF.md
# Program Counter Branch Unit

This block owns the program counter of a small word-addressed 8-bit microcontroller core. On every cycle in which `step` is high, it takes one decoded control-transfer kind and produces the next program-counter value. The kinds are:

- plain sequential advance;
- jumps and calls with a direct 22-bit target;
- jumps and calls with a signed 12-bit relative offset;
- jumps and calls through the 16-bit Z pointer;
- subroutine return;
- a conditional branch that tests one of the Z, C, N or V status flags.

Calls push their return address onto an internal eight-entry return stack, and returns pop it. Every transfer that is taken raises `flush` for one cycle. The pipeline uses `flush` to drop the instruction it has already fetched.

The unit has no back-pressure. `step` is a plain qualifier, and a cycle without it leaves the program counter and the stack untouched. The operand inputs (`abs_target`, `rel_off`, `br_off`, `cond_sel`, the flags and `zptr`) only matter in a cycle where `step` is high and `kind` selects them. The unit accepts a new control-transfer kind on every cycle.

Top module: `pc_steer`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it goes high, `pc` is 0, `flush` is 0 and `stack_err` is 0, and the return stack is empty.
- R2: In a cycle with `step` low, `pc`, `flush` is cleared and the stack is unchanged. With `step` high and `kind`=0 (sequential), `pc` becomes `pc`+1 modulo 2^22.
- R3: `kind`=1 (absolute jump) loads `pc` with `abs_target`. All 22-bit values are reachable, and 0x3FFFFF advances to 0 on the next sequential step.
- R4: `kind`=2 (relative jump) loads `pc`+1 plus the sign-extended 12-bit `rel_off`, modulo 2^22, so both backward and forward moves are possible.
- R5: `kind`=3 (indirect jump) loads `pc` with `zptr` zero-extended to 22 bits.
- R6: `kind`=8 (conditional branch) goes to `pc`+1 plus the sign-extended 7-bit `br_off` when the condition chosen by `cond_sel` holds. Otherwise it goes to `pc`+1. The `cond_sel` codes are: 0 C=1, 1 C=0, 2 Z=1, 3 Z=0, 4 N=1, 5 N=0, 6 V=1, 7 V=0.
- R7: Calls transfer like the matching jump and push a return address. `kind`=4 is an absolute call and pushes `pc`+2. `kind`=5 is a relative call and `kind`=6 is an indirect call, and both push `pc`+1.
- R8: `kind`=7 (return) loads `pc` with the most recently pushed address that has not yet been popped.
- R9: A call with 8 entries already stored, or a return with none stored, sets `stack_err`. `stack_err` then stays set until reset, and the stack contents are not changed. An overflowing call still transfers. An underflowing return advances to `pc`+1 and is not taken.
- R10: `flush` is high in the cycle after a step whose transfer is taken: any jump, any call, a return with a stored entry, or a branch whose condition holds. It is low after every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Qualifies `kind` and the operands for this cycle |
| kind | input | 4 | Control-transfer kind (codes in R2 to R8) |
| cond_sel | input | 3 | Branch condition selector (codes in R6) |
| abs_target | input | 22 | Direct target for an absolute jump or call |
| rel_off | input | 12 | Signed offset for a relative jump or call |
| br_off | input | 7 | Signed offset for a conditional branch |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| zptr | input | 16 | Z pointer for indirect transfers |
| pc | output | 22 | Current program counter |
| flush | output | 1 | One-cycle marker of a taken transfer |
| stack_err | output | 1 | Sticky return-stack overflow or underflow flag |

## Verification
The bench builds the unit with its defaults: a 22-bit counter, 12-bit and 7-bit offsets, a 16-bit pointer and eight stack entries. The 22-bit width lets one absolute jump to 0x3FFFFF, followed by a step, show the modulo-2^22 wrap. Relative offsets taken from small counter values show the backward wrap through zero. The depth of eight makes the overflow reachable with nine nested calls. Eight returns then confirm that the entries stored before the overflow were not disturbed, and a ninth return reaches underflow.

// File: rtl/pc_steer_pkg.sv
package pc_steer_pkg;
  typedef enum logic [3:0] {
    XK_SEQ  = 4'd0,
    XK_JABS = 4'd1,
    XK_JREL = 4'd2,
    XK_JIND = 4'd3,
    XK_CABS = 4'd4,
    XK_CREL = 4'd5,
    XK_CIND = 4'd6,
    XK_RET  = 4'd7,
    XK_BRC  = 4'd8
  } xfer_kind_e;

  typedef enum logic [2:0] {
    CS_CSET = 3'd0,
    CS_CCLR = 3'd1,
    CS_ZSET = 3'd2,
    CS_ZCLR = 3'd3,
    CS_NSET = 3'd4,
    CS_NCLR = 3'd5,
    CS_VSET = 3'd6,
    CS_VCLR = 3'd7
  } cond_sel_e;
endpackage

// File: rtl/pc_cond_eval.sv
module pc_cond_eval (
  input  logic [2:0] sel,
  input  logic       fz,
  input  logic       fc,
  input  logic       fn,
  input  logic       fv,
  output logic       hit
);
  logic [7:0] cand;
  // even codes test a flag set, odd codes test it clear
  assign cand = {~fv, fv, ~fn, fn, ~fz, fz, ~fc, fc};
  assign hit  = cand[sel];
endmodule

// File: rtl/pc_target_calc.sv
module pc_target_calc #(
  parameter int PC_W  = 22,
  parameter int REL_W = 12,
  parameter int BR_W  = 7,
  parameter int ZP_W  = 16
) (
  input  logic [PC_W-1:0]  pc_cur,
  input  logic [REL_W-1:0] rel_off,
  input  logic [BR_W-1:0]  br_off,
  input  logic [ZP_W-1:0]  zptr,
  output logic [PC_W-1:0]  inc1,
  output logic [PC_W-1:0]  inc2,
  output logic [PC_W-1:0]  rel_tgt,
  output logic [PC_W-1:0]  br_tgt,
  output logic [PC_W-1:0]  ind_tgt
);
  localparam int REL_PAD = PC_W - REL_W;
  localparam int BR_PAD  = PC_W - BR_W;
  localparam int ZP_PAD  = PC_W - ZP_W;

  logic [PC_W-1:0] rel_ext, br_ext;

  assign rel_ext = {{REL_PAD{rel_off[REL_W-1]}}, rel_off};
  assign br_ext  = {{BR_PAD{br_off[BR_W-1]}}, br_off};

  assign inc1    = pc_cur + PC_W'(1);
  assign inc2    = pc_cur + PC_W'(2);
  assign rel_tgt = inc1 + rel_ext;
  assign br_tgt  = inc1 + br_ext;
  assign ind_tgt = {{ZP_PAD{1'b0}}, zptr};
endmodule

// File: rtl/pc_ret_stack.sv
module pc_ret_stack #(
  parameter int W     = 22,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         err
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_m1;
  logic          full;

  assign full   = (cnt == CW'(DEPTH));
  assign empty  = (cnt == '0);
  assign cnt_m1 = cnt - CW'(1);
  assign dout   = mem[cnt_m1[PW-1:0]];

  always_ff @(posedge clk) begin
    if (push && !full) mem[cnt[PW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      err <= 1'b0;
    end else begin
      if (push) begin
        if (full) err <= 1'b1;
        else      cnt <= cnt + CW'(1);
      end else if (pop) begin
        if (empty) err <= 1'b1;
        else       cnt <= cnt_m1;
      end
    end
  end
endmodule

// File: rtl/pc_steer.sv
module pc_steer
  import pc_steer_pkg::*;
#(
  parameter int PC_W  = 22,
  parameter int REL_W = 12,
  parameter int BR_W  = 7,
  parameter int ZP_W  = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [3:0]       kind,
  input  logic [2:0]       cond_sel,
  input  logic [PC_W-1:0]  abs_target,
  input  logic [REL_W-1:0] rel_off,
  input  logic [BR_W-1:0]  br_off,
  input  logic             flag_z,
  input  logic             flag_c,
  input  logic             flag_n,
  input  logic             flag_v,
  input  logic [ZP_W-1:0]  zptr,
  output logic [PC_W-1:0]  pc,
  output logic             flush,
  output logic             stack_err
);
  logic [PC_W-1:0] inc1, inc2, rel_tgt, br_tgt, ind_tgt;
  logic [PC_W-1:0] stk_top, ret_addr, nxt;
  logic            cond_hit, stk_empty, taken, do_push, do_pop;
  xfer_kind_e      k;

  assign k = xfer_kind_e'(kind);

  pc_target_calc #(.PC_W(PC_W), .REL_W(REL_W), .BR_W(BR_W), .ZP_W(ZP_W)) u_tgt (
    .pc_cur(pc), .rel_off(rel_off), .br_off(br_off), .zptr(zptr),
    .inc1(inc1), .inc2(inc2), .rel_tgt(rel_tgt), .br_tgt(br_tgt), .ind_tgt(ind_tgt)
  );

  pc_cond_eval u_cond (
    .sel(cond_sel), .fz(flag_z), .fc(flag_c), .fn(flag_n), .fv(flag_v), .hit(cond_hit)
  );

  pc_ret_stack #(.W(PC_W), .DEPTH(DEPTH)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(do_push), .pop(do_pop),
    .din(ret_addr), .dout(stk_top), .empty(stk_empty), .err(stack_err)
  );

  assign ret_addr = (k == XK_CABS) ? inc2 : inc1;
  assign do_push  = step && (k == XK_CABS || k == XK_CREL || k == XK_CIND);
  assign do_pop   = step && (k == XK_RET);

  always_comb begin
    nxt   = inc1;
    taken = 1'b0;
    unique case (k)
      XK_JABS, XK_CABS: begin nxt = abs_target; taken = 1'b1; end
      XK_JREL, XK_CREL: begin nxt = rel_tgt;    taken = 1'b1; end
      XK_JIND, XK_CIND: begin nxt = ind_tgt;    taken = 1'b1; end
      XK_RET: begin
        if (!stk_empty) begin nxt = stk_top; taken = 1'b1; end
      end
      XK_BRC: begin
        if (cond_hit) begin nxt = br_tgt; taken = 1'b1; end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc    <= '0;
      flush <= 1'b0;
    end else begin
      flush <= step && taken;
      if (step) pc <= nxt;
    end
  end
endmodule

// File: rtl/pc_steer_chk.sv
module pc_steer_chk
  import pc_steer_pkg::*;
#(
  parameter int PC_W = 22,
  parameter int ZP_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            step,
  input logic [3:0]      kind,
  input logic [PC_W-1:0] abs_target,
  input logic [ZP_W-1:0] zptr,
  input logic [PC_W-1:0] pc,
  input logic            flush,
  input logic            stack_err
);
  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pc));

  a_r2_seq_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (step && kind == XK_SEQ) |=> (pc == $past(pc) + PC_W'(1)) && !flush);

  a_r3_abs_load: assert property (@(posedge clk) disable iff (!rst_n)
    (step && kind == XK_JABS) |=> (pc == $past(abs_target)) && flush);

  a_r5_ind_load: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (kind == XK_JIND || kind == XK_CIND)) |=>
      (pc == {{(PC_W-ZP_W){1'b0}}, $past(zptr)}));

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stack_err |=> stack_err);

  a_r10_no_flush_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> !flush);
endmodule

bind pc_steer pc_steer_chk #(.PC_W(PC_W), .ZP_W(ZP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .kind(kind), .abs_target(abs_target),
  .zptr(zptr), .pc(pc), .flush(flush), .stack_err(stack_err)
);

// File: tb/pc_steer_test.sv
module pc_steer_test;
  import pc_steer_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0;
  logic [3:0]  kind = '0;
  logic [2:0]  cond_sel = '0;
  logic [21:0] abs_target = '0;
  logic [11:0] rel_off = '0;
  logic [6:0]  br_off = '0;
  logic        flag_z = 0, flag_c = 0, flag_n = 0, flag_v = 0;
  logic [15:0] zptr = '0;
  logic [21:0] pc;
  logic        flush, stack_err;

  int checks = 0, fails = 0, cycles = 0;

  logic [21:0] m_pc = '0;
  logic [21:0] m_stk [DEPTH];
  int          m_cnt = 0;
  logic        m_err = 1'b0;

  logic [23:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_steer uut (
    .clk(clk), .rst_n(rst_n), .step(step), .kind(kind), .cond_sel(cond_sel),
    .abs_target(abs_target), .rel_off(rel_off), .br_off(br_off),
    .flag_z(flag_z), .flag_c(flag_c), .flag_n(flag_n), .flag_v(flag_v),
    .zptr(zptr), .pc(pc), .flush(flush), .stack_err(stack_err)
  );

  task automatic compare(input string tag, input logic [23:0] exp);
    logic [23:0] got;
    got = {pc, flush, stack_err};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got pc=%h flush=%b err=%b, expected pc=%h flush=%b err=%b",
               tag, got[23:2], got[1], got[0], exp[23:2], exp[1], exp[0]);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the modelled result
  task automatic issue(input string tag, input bit st, input logic [3:0] k,
                       input logic [2:0] cs = 0, input logic [21:0] a = 0,
                       input logic [11:0] r = 0, input logic [6:0] b = 0,
                       input logic [3:0] f = 0, input logic [15:0] zp = 0);
    logic [21:0] p1, nxt;
    logic        tk, hit;
    @(negedge clk);
    step = st; kind = k; cond_sel = cs; abs_target = a; rel_off = r; br_off = b;
    {flag_z, flag_c, flag_n, flag_v} = f; zptr = zp;
    p1 = m_pc + 22'd1;
    nxt = p1; tk = 1'b0;
    case (cs)
      3'd0: hit = f[2];  3'd1: hit = !f[2];
      3'd2: hit = f[3];  3'd3: hit = !f[3];
      3'd4: hit = f[1];  3'd5: hit = !f[1];
      3'd6: hit = f[0];  default: hit = !f[0];
    endcase
    if (st) begin
      case (k)
        4'd1, 4'd4: begin nxt = a; tk = 1; end
        4'd2, 4'd5: begin nxt = p1 + {{10{r[11]}}, r}; tk = 1; end
        4'd3, 4'd6: begin nxt = {6'd0, zp}; tk = 1; end
        4'd7: if (m_cnt > 0) begin m_cnt--; nxt = m_stk[m_cnt]; tk = 1; end
              else m_err = 1;
        4'd8: if (hit) begin nxt = p1 + {{15{b[6]}}, b}; tk = 1; end
        default: ;
      endcase
      if (k == 4'd4 || k == 4'd5 || k == 4'd6) begin
        if (m_cnt < DEPTH) begin
          m_stk[m_cnt] = (k == 4'd4) ? m_pc + 22'd2 : p1;
          m_cnt++;
        end else m_err = 1;
      end
      m_pc = nxt;
    end
    exp_q.push_back({m_pc, tk, m_err});
    tag_q.push_back(tag);
  endtask

  // monitor: each queued item is due just after the next rising edge
  initial begin
    forever begin
      @(posedge clk);
      if (exp_q.size() > 0) begin
        #2;
        compare(tag_q.pop_front(), exp_q.pop_front());
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        fails++;
        $display("FAIL watchdog: got %0d cycles, expected at most 5000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 during reset", 24'd0);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after release", 24'd0);

    // R2 sequential and idle
    issue("R2 seq", 1, XK_SEQ);
    issue("R2 seq", 1, XK_SEQ);
    issue("R2 idle ignores jump", 0, XK_JABS, 0, 22'h123456);
    issue("R2 idle", 0, XK_SEQ);

    // R3 absolute, wrap at top
    issue("R3 abs to top", 1, XK_JABS, 0, 22'h3FFFFF);
    issue("R3 wrap to zero", 1, XK_SEQ);
    issue("R3 abs mid", 1, XK_JABS, 0, 22'h000100);

    // R4 relative forward, backward, wrap below zero
    issue("R4 rel fwd", 1, XK_JREL, 0, 0, 12'h7FF);
    issue("R4 rel back", 1, XK_JREL, 0, 0, 12'h800);
    issue("R4 abs setup", 1, XK_JABS, 0, 22'h000002);
    issue("R4 rel wrap under", 1, XK_JREL, 0, 0, 12'hFF0);

    // R5 indirect
    issue("R5 ind", 1, XK_JIND, 0, 0, 0, 0, 0, 16'hFFFF);
    issue("R5 ind zero", 1, XK_JIND, 0, 0, 0, 0, 0, 16'h0000);

    // R6 all eight conditions, each true then false (flags {z,c,n,v})
    for (int cs = 0; cs < 8; cs++) begin
      logic [3:0] ftrue;
      case (cs)
        0: ftrue = 4'b0100; 1: ftrue = 4'b1011;
        2: ftrue = 4'b1000; 3: ftrue = 4'b0111;
        4: ftrue = 4'b0010; 5: ftrue = 4'b1101;
        6: ftrue = 4'b0001; default: ftrue = 4'b1110;
      endcase
      issue("R6 branch taken", 1, XK_BRC, cs[2:0], 0, 0, 7'h05, ftrue);
      issue("R6 branch not taken", 1, XK_BRC, cs[2:0], 0, 0, 7'h05, ~ftrue);
      issue("R6 branch back", 1, XK_BRC, cs[2:0], 0, 0, 7'h7A, ftrue);
    end

    // R7/R8 single call of each kind and its return
    issue("R7 setup", 1, XK_JABS, 0, 22'h001000);
    issue("R7 abs call", 1, XK_CABS, 0, 22'h002000);
    issue("R8 ret abs", 1, XK_RET);
    issue("R7 rel call", 1, XK_CREL, 0, 0, 12'h010);
    issue("R8 ret rel", 1, XK_RET);
    issue("R7 ind call", 1, XK_CIND, 0, 0, 0, 0, 0, 16'h4321);
    issue("R8 ret ind", 1, XK_RET);
    issue("R10 seq no flush", 1, XK_SEQ);

    // R9 overflow with nine nested calls, then unwind and underflow
    for (int i = 0; i < DEPTH; i++)
      issue("R7 nested call", 1, XK_CABS, 0, 22'h010000 + 22'(i * 16));
    issue("R9 overflow call", 1, XK_CREL, 0, 0, 12'h004);
    issue("R9 idle keeps err", 0, XK_SEQ);
    for (int i = 0; i < DEPTH; i++)
      issue("R9 unwind intact", 1, XK_RET);
    issue("R9 underflow ret", 1, XK_RET);
    issue("R10 after underflow", 1, XK_SEQ);

    issue("R2 final idle", 0, XK_SEQ);
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule